// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Edge Resynchronization

This block turns the receive wire of a CAN bus into one sampled bit per nominal bit time. The wire is oversampled by the fabric clock. A clock-enable input `tick_en` marks the oversampling ticks that count. The bit period and the distance from the start of a bit to its sample point are tick counts on configuration ports. The block captures them while reset is held and keeps them until the next reset. For a 1 Mbit/s bus sampled at 10 MHz with the sample point at 70 %, these are 10 and 7.

While idle, the block watches the synchronized line. The first tick that sees a dominant (low) level is a hard sync: the frame starts there and the raw bit counter restarts at zero. Within a frame, the sample instant of a bit is the tick of the latest timing anchor, plus `offset`, plus `period` times the number of bits sampled since that anchor. A recessive-to-dominant edge seen on a tick that is not itself a sample tick moves the anchor to that tick. This absorbs a small rate mismatch between transmitter and receiver.

The block counts every sampled bit, stuff bits included, because it does not know the frame layout. A downstream frame decoder raises `frame_done` when it has seen the end of the frame, and the block then returns to idle.

Top module: `can_bit_sampler`

## Requirements
- R1: While `rst_n` is low, `bit_stb`, `frame_active` and `bit_num` are all 0 after the next clock edge.
- R2: In idle, the first tick at which the synchronized line is 0 starts a frame. The synchronizer gives the line to the timing logic two clocks after `rx_in`. `frame_active` is 1 from that clock edge on, and the first strobe of the frame reports `bit_num` 0.
- R3: The first sample of a frame falls `offset` ticks after the hard-sync tick. Without edges, each later sample follows the previous one by `period` ticks. This holds at the minimum period of 4 ticks and at both extreme offsets, 1 and `period`−1.
- R4: In a frame, a 1-to-0 change of the synchronized line, seen on a tick that is not a sample tick, makes the next sample fall `offset` ticks after that tick.
- R5: When a 1-to-0 change falls on a sample tick, the bit is sampled with value 0 and the next sample is `period` ticks later. The edge does not re-anchor.
- R6: A strobe is a one-clock pulse of `bit_stb` in the clock after the sample tick. `bit_val` carries the synchronized line level at that tick (1 = recessive, 0 = dominant).
- R7: `bit_num` counts up by one on each strobe of a frame, stuff bits included, starting from 0.
- R8: `frame_done` high at a clock edge forces idle at that edge. `frame_active` is 0 and no strobe follows until a new dominant level is seen.
- R9: 0-to-1 changes of the line never move the sample grid.
- R10: A clock edge with `tick_en` low advances nothing. It produces no strobe and leaves `bit_num` and `frame_active` unchanged.
- R11: `period` and `offset` are taken from `cfg_period` and `cfg_offset` only while `rst_n` is low. Later changes on those ports have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the configuration |
| tick_en | input | 1 | Oversampling tick enable |
| rx_in | input | 1 | Asynchronous CAN receive wire |
| cfg_period | input | CNT_W | Ticks per bit, at least 4 |
| cfg_offset | input | CNT_W | Ticks from bit start to sample point, 1 to period−1 |
| frame_done | input | 1 | Return to idle |
| bit_val | output | 1 | Value of the last sampled bit |
| bit_stb | output | 1 | One-clock pulse per sampled bit |
| bit_num | output | IDX_W | Raw index of the bit in `bit_val` |
| frame_active | output | 1 | High from hard sync until `frame_done` |

## Verification
The hardest case to reach from the ports is a dominant edge that lands exactly on a sample tick, because the sample grid is only visible through the strobes and the line passes through two synchronizer flops. The bench times its line segments from the drive cycle that caused the hard sync. This places a falling edge on the predicted sample tick and shows whether the following strobe stays on the old grid. Random bit lengths with ±2 ticks of jitter, random tick gating and a `frame_done` pulse while the line is still dominant cover the resynchronization and re-sync paths. A tick-by-tick reference model of the requirements checks all of these runs.

// File: rtl/can_smp_pkg.sv
package can_smp_pkg;
   typedef enum logic {
      SMP_IDLE  = 1'b0,
      SMP_FRAME = 1'b1
   } smp_state_e;
endpackage

// File: rtl/can_smp_sync.sv
// Multi-flop synchronizer for the asynchronous receive wire.
module can_smp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("can_smp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/can_smp_edge.sv
// Remembers the line level at the previous tick and flags a recessive-to-dominant change.
module can_smp_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    prev_q <= 1'b1;
      else if (tick) prev_q <= line;
   end

   assign fall = tick & prev_q & ~line;
endmodule

// File: rtl/can_smp_timer.sv
// Countdown to the next sample tick; reloads from the anchor or from the last sample.
module can_smp_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             active,
   input  logic             anchor,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] offset,
   output logic             hit
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] remain;

   assign hit = active & tick & (remain == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (tick) begin
         if (anchor)             remain <= offset - ONE;
         else if (hit)           remain <= period - ONE;
         else if (remain != '0)  remain <= remain - ONE;
      end
   end

   // the countdown never reaches the programmed period
   assert_remain_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      remain < period);
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
   import can_smp_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int IDX_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             rx_in,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic [CNT_W-1:0] cfg_offset,
   input  logic             frame_done,
   output logic             bit_val,
   output logic             bit_stb,
   output logic [IDX_W-1:0] bit_num,
   output logic             frame_active
);
   localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(4);
   localparam logic [IDX_W-1:0] IDX_ONE    = {{(IDX_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("can_bit_sampler: CNT_W must hold a period of 4");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("can_bit_sampler: IDX_W must be positive");
      end
   endgenerate

   smp_state_e       state;
   logic [CNT_W-1:0] per_q, off_q;
   logic [IDX_W-1:0] idx_q;
   logic             line, fall, hit, anchor, in_frame;

   can_smp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_in), .q(line));

   can_smp_edge u_edge (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .line(line), .fall(fall));

   assign in_frame = (state == SMP_FRAME);

   // hard sync in idle, edge resync in a frame unless the edge sits on a sample tick
   assign anchor = tick_en & ~frame_done &
                   (in_frame ? (fall & ~hit) : ~line);

   can_smp_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .active(in_frame),
      .anchor(anchor), .period(per_q), .offset(off_q), .hit(hit));

   // configuration is captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q <= cfg_period;
         off_q <= cfg_offset;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SMP_IDLE;
         idx_q   <= '0;
         bit_stb <= 1'b0;
         bit_val <= 1'b1;
         bit_num <= '0;
      end else begin
         bit_stb <= 1'b0;
         if (frame_done) begin
            state <= SMP_IDLE;
         end else if (tick_en) begin
            if (!in_frame) begin
               if (!line) begin
                  state <= SMP_FRAME;
                  idx_q <= '0;
               end
            end else if (hit) begin
               bit_stb <= 1'b1;
               bit_val <= line;
               bit_num <= idx_q;
               idx_q   <= idx_q + IDX_ONE;
            end
         end
      end
   end

   assign frame_active = in_frame;

   always @(posedge clk) begin
      if (rst_n) begin
         assert_cfg_range_R11: assert (per_q >= MIN_PERIOD && off_q != '0 && off_q < per_q)
            else $error("sampler configuration out of range");
      end
   end

   assert_stb_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> frame_active);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (!frame_active && !bit_stb));

   assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !frame_done) |=> (!bit_stb && $stable(bit_num) && $stable(frame_active)));

   assert_cfg_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($stable(per_q) && $stable(off_q)));
endmodule

// File: tb/can_bit_sampler_test.sv
module can_bit_sampler_test;
   localparam int CNT_W = 8;
   localparam int IDX_W = 10;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n, tick_en, rx_in, frame_done;
   logic [CNT_W-1:0] cfg_period, cfg_offset;
   logic             bit_val, bit_stb, frame_active;
   logic [IDX_W-1:0] bit_num;

   can_bit_sampler #(.CNT_W(CNT_W), .IDX_W(IDX_W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_in(rx_in),
      .cfg_period(cfg_period), .cfg_offset(cfg_offset), .frame_done(frame_done),
      .bit_val(bit_val), .bit_stb(bit_stb), .bit_num(bit_num),
      .frame_active(frame_active));

   int    errors = 0, checks = 0;
   bit    finished = 1'b0;
   string scen = "R2";
   int    tick_mode = 0;
   bit    tick_ph = 1'b0;
   bit    done_req = 1'b0;

   // reference model state, driven by the requirements
   int   m_per, m_off, m_t, m_next, m_idx;
   bit   m_act, m_prev;
   logic w1, w2;
   bit   cur_tick, cur_done;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // line seen by the timing logic at edge e equals rx_in driven for edge e-2
   task automatic step(input logic lvl);
      bit   es;
      int   ev, en;
      logic ln;
      @(negedge clk);
      es = 1'b0; ev = 0; en = 0; ln = w2;
      if (cur_done) begin
         m_act = 1'b0;
      end else if (cur_tick) begin
         if (!m_act) begin
            if (ln == 1'b0) begin
               m_act = 1'b1; m_idx = 0; m_next = m_t + m_off;
            end
         end else if (m_t == m_next) begin
            es = 1'b1; ev = int'(ln); en = m_idx;
            m_idx++; m_next = m_t + m_per;
         end else if (m_prev && ln == 1'b0) begin
            m_next = m_t + m_off;
         end
      end
      if (cur_tick) begin
         m_prev = ln; m_t++;
      end
      chk(bit_stb == es, scen, "bit_stb", int'(bit_stb), int'(es));
      if (es) begin
         chk(int'(bit_val) == ev, scen, "bit_val R6", int'(bit_val), ev);
         chk(int'(bit_num) == en, scen, "bit_num R7", int'(bit_num), en);
      end
      chk(frame_active == m_act, scen, "frame_active", int'(frame_active), int'(m_act));
      w2 = w1; w1 = rx_in;
      rx_in = lvl;
      case (tick_mode)
         0:       tick_en = 1'b1;
         1:       tick_en = (($urandom % 4) != 0);
         default: begin tick_ph = ~tick_ph; tick_en = tick_ph; end
      endcase
      frame_done = done_req; done_req = 1'b0;
      cur_tick = tick_en; cur_done = frame_done;
   endtask

   task automatic seg(input logic lvl, input int n);
      for (int i = 0; i < n; i++) step(lvl);
   endtask

   task automatic do_reset(input int per, input int off);
      @(negedge clk);
      rst_n = 1'b0; rx_in = 1'b1; tick_en = 1'b1; frame_done = 1'b0;
      cfg_period = CNT_W'(per); cfg_offset = CNT_W'(off);
      repeat (4) @(negedge clk);
      chk(bit_stb == 1'b0, "R1", "bit_stb in reset", int'(bit_stb), 0);
      chk(frame_active == 1'b0, "R1", "frame_active in reset", int'(frame_active), 0);
      chk(bit_num == '0, "R1", "bit_num in reset", int'(bit_num), 0);
      m_per = per; m_off = off; m_t = 0; m_next = 0; m_idx = 0;
      m_act = 1'b0; m_prev = 1'b1; w1 = 1'b1; w2 = 1'b1;
      rst_n = 1'b1; cur_tick = 1'b1; cur_done = 1'b0; tick_ph = 1'b0;
   endtask

   function automatic int bit_len(input int scale, input int jit);
      int d;
      d = scale * m_per;
      if (jit > 0) d = d + int'($urandom_range(2 * jit)) - jit;
      return d;
   endfunction

   task automatic send_frame(input int nbits, input int jit, input int scale);
      seg(1'b0, bit_len(scale, 0));
      for (int b = 0; b < nbits; b++) seg(logic'($urandom % 2), bit_len(scale, jit));
      seg(1'b1, 3);
      done_req = 1'b1;
      seg(1'b1, 4 * scale * m_per);
   endtask

   initial begin
      rst_n = 1'b0; rx_in = 1'b1; tick_en = 1'b1; frame_done = 1'b0;
      cfg_period = 8'd10; cfg_offset = 8'd7;
      void'($urandom(32'd20240611));

      // R2: hard sync and first index
      do_reset(10, 7);
      scen = "R2";
      seg(1'b1, 6);
      send_frame(12, 0, 1);

      // R3: clean grid, nominal and minimum period with extreme offsets
      scen = "R3";
      send_frame(30, 0, 1);
      do_reset(4, 1);
      send_frame(25, 0, 1);
      do_reset(4, 3);
      send_frame(25, 0, 1);

      // R4: late and early edges re-anchor the grid
      do_reset(10, 7);
      scen = "R4";
      seg(1'b1, 5);
      seg(1'b0, 10); seg(1'b1, 13); seg(1'b0, 10); seg(1'b1, 8); seg(1'b0, 12);
      seg(1'b1, 20);
      done_req = 1'b1; seg(1'b1, 10);
      send_frame(40, 2, 1);

      // R5: falling edge exactly on a sample tick
      scen = "R5";
      seg(1'b1, 5);
      seg(1'b0, 9); seg(1'b1, 8); seg(1'b0, 6); seg(1'b1, 30);
      done_req = 1'b1; seg(1'b1, 10);

      // R9: rising edges off the grid leave it unchanged
      scen = "R9";
      seg(1'b0, 3); seg(1'b1, 4); seg(1'b0, 2); seg(1'b1, 60);
      done_req = 1'b1; seg(1'b1, 10);

      // R8: frame end while dominant, then while recessive
      scen = "R8";
      seg(1'b0, 14);
      done_req = 1'b1; seg(1'b0, 8);
      seg(1'b1, 25);
      done_req = 1'b1; seg(1'b1, 40);

      // R10: gated ticks
      scen = "R10";
      tick_mode = 2;
      send_frame(20, 0, 2);
      tick_mode = 1;
      send_frame(20, 0, 1);
      tick_mode = 0;

      // R11: ports change after reset, then a new reset loads them
      scen = "R11";
      cfg_period = 8'd20; cfg_offset = 8'd3;
      send_frame(20, 1, 1);
      do_reset(12, 5);
      send_frame(20, 2, 1);

      // R6 / R7: random frames, long frames
      do_reset(10, 7);
      scen = "R6";
      for (int f = 0; f < 25; f++) send_frame(10 + int'($urandom % 50), int'($urandom % 3), 1);
      scen = "R7";
      send_frame(120, 1, 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule